// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking in-memory translation tables. A walk starts from a per-context root. The root descriptor sits at an address formed from a context table pointer and the current context number. From there the walker follows pointer descriptors through up to three table levels until it meets a page table entry. A leaf at the first, second or third level maps a 16 MB, 256 KB or 4 KB page. The walker reads descriptors as 32-bit words over a simple request/response memory port. It returns the physical address, the page size and the final entry. When a walk stops early it returns a fault code that records the table level where it stopped and the kind of error.

On a successful walk the walker keeps the entry's referenced and modified flags up to date. It writes the entry back to the address it was read from when the referenced flag is clear, or when a write access finds the modified flag clear. When translation is switched off, addresses pass straight through. In that mode, an instruction fetch under boot mode is redirected into a boot ROM window. Permission checking and caching of translations are handled by other blocks. This walker serves one request at a time.

Top module: `ptw_walker`

## Requirements
- R1: The walker takes a request when `req_valid` and `req_ready` are both high. `req_ready` is high only while the walker is idle. For a table walk, `busy` is high from the cycle after acceptance until it falls in the same cycle that `done` or `fault` pulses.
- R2: The first descriptor read of a walk goes to address `(ctx_ptr << 4) + (ctx_num << 2)`.
- R3: Bits [1:0] of a descriptor give its type: 0 invalid, 1 pointer to the next table, 2 page entry, 3 reserved. For a pointer, the next read address is `(desc & ~3) << 4` plus an index. The index is `VA[31:24]*4` after the root descriptor, `VA[23:18]*4` after a first-level pointer and `VA[17:12]*4` after a second-level pointer. A request that is held off by `mem_req_ready` keeps its address steady.
- R4: A page entry found in the first-level table gives a 16 MB page. Then `res_size` is 2 and `res_pa` is `(entry[31:8] << 12) + (VA[23:12] << 12)`.
- R5: A page entry found in the second-level table gives a 256 KB page, with `res_size` 1 and the offset `VA[17:12] << 12`. One found in the third-level table gives a 4 KB page, with `res_size` 0 and no offset.
- R6: An invalid descriptor at level L (root = 0, then 1 to 3 for the table levels) ends the walk with `fault` and `fault_code = (L << 8) | 0x004`.
- R7: A reserved descriptor at any level, a page entry at the root, or a pointer at level 3 ends the walk with `fault_code = (L << 8) | 0x010`.
- R8: A descriptor read that returns with `mem_rsp_err` high ends the walk with `fault_code = (L << 8) | 0x010`, where L is the level of that read.
- R9: The referenced flag is bit 5 of an entry and the modified flag is bit 6. If bit 5 is clear, or the access is a write (`req_acc` = 1) and bit 6 is clear, the walker writes the entry back to the same address with bit 5 set, and with bit 6 also set on a write, before it raises `done`. `res_pte` holds the updated entry. Otherwise the walker writes nothing.
- R10: With `cfg_enable` low, a request completes with `done` on the clock edge after acceptance. It makes no memory access, and it returns `res_pa` equal to the zero-extended VA with `res_size` 0.
- R11: With `cfg_enable` low and `cfg_boot` high, an instruction fetch (`req_acc` = 2) returns `prom_base | VA[18:0]`. A read under the same settings still passes the VA through unchanged.
- R12: `done` and `fault` are single-cycle pulses and are never high together. The result outputs stay steady after `done` until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Translation enable |
| cfg_boot | input | 1 | Boot mode: redirect fetches to ROM when translation is off |
| ctx_ptr | input | 32 | Context table pointer (physical address >> 4) |
| ctx_num | input | CTX_W | Current context number |
| prom_base | input | PA_W | Boot ROM base physical address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Faulted completion pulse |
| fault_code | output | 12 | (level << 8) \| (type << 2) |
| res_pa | output | PA_W | Translated physical address |
| res_size | output | 2 | Page size: 0 = 4 KB, 1 = 256 KB, 2 = 16 MB |
| res_pte | output | 32 | Final (updated) page entry |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | PA_W | Memory word address (byte address) |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | 32 | Read data |
| mem_rsp_err | input | 1 | Bus error on this read response |

## Verification
The checks assume the memory returns exactly one response for each request it accepts, and never a response that nothing asked for. They also assume the configuration inputs stay constant while a walk is running, and that `req_acc` never takes the value 3. The bench memory model answers each accepted request on the next cycle, with the error flag only when a test arms it. It changes configuration and page tables only between walks. One pass throttles `mem_req_ready` to exercise the held-request rule.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    DT_INVALID  = 2'd0,
    DT_POINTER  = 2'd1,
    DT_ENTRY    = 2'd2,
    DT_RESERVED = 2'd3
  } desc_type_e;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_256K = 2'd1,
    PG_16M  = 2'd2
  } page_size_e;

  typedef enum logic [1:0] {
    STEP_DESCEND = 2'd0,
    STEP_LEAF    = 2'd1,
    STEP_FAULT   = 2'd2
  } step_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int FC_W       = 12;
  localparam int REF_BIT    = 5;
  localparam int MOD_BIT    = 6;
  localparam int LAST_LEVEL = 3;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_XLATE   = 3'd4;

endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input  logic [31:0]      ctx_ptr,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic [29:0]      desc_base,
  input  logic [1:0]       lvl,
  input  logic [19:0]      va_hi,
  output logic [PA_W-1:0]  root_addr,
  output logic [PA_W-1:0]  next_addr
);
  localparam int IDX_W = 10;

  logic [IDX_W-1:0] idx;

  always_comb begin
    case (lvl)
      2'd0:    idx = {va_hi[19:12], 2'b00};
      2'd1:    idx = {2'b00, va_hi[11:6], 2'b00};
      2'd2:    idx = {2'b00, va_hi[5:0], 2'b00};
      default: idx = '0;
    endcase
  end

  assign root_addr = PA_W'({ctx_ptr, 4'b0000}) + PA_W'({ctx_num, 2'b00});
  assign next_addr = PA_W'({desc_base, 6'b000000}) + PA_W'(idx);

endmodule

// File: rtl/ptw_classify.sv
module ptw_classify
  import ptw_pkg::*;
(
  input  logic [1:0]      dtype,
  input  logic [1:0]      lvl,
  input  logic            bus_err,
  output step_e           step,
  output logic [FC_W-1:0] code
);
  logic [2:0] ftype;

  always_comb begin
    step  = STEP_FAULT;
    ftype = FT_XLATE;
    if (!bus_err) begin
      case (desc_type_e'(dtype))
        DT_INVALID: ftype = FT_INVALID;
        DT_POINTER: if (lvl != 2'(LAST_LEVEL)) step = STEP_DESCEND;
        DT_ENTRY:   if (lvl != 2'd0) step = STEP_LEAF;
        default:    ftype = FT_XLATE;
      endcase
    end
    code = (FC_W'(lvl) << 8) | (FC_W'(ftype) << 2);
  end

endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
  import ptw_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic [31:0]     entry,
  input  logic [1:0]      lvl,
  input  logic [11:0]     va_mid,
  input  logic            is_write,
  output logic [PA_W-1:0] pa,
  output page_size_e      size,
  output logic [31:0]     upd_entry,
  output logic            need_wb
);
  logic [23:0] offset;

  always_comb begin
    case (lvl)
      2'd1: begin
        offset = {va_mid, 12'h000};
        size   = PG_16M;
      end
      2'd2: begin
        offset = {6'd0, va_mid[5:0], 12'h000};
        size   = PG_256K;
      end
      default: begin
        offset = '0;
        size   = PG_4K;
      end
    endcase
  end

  assign pa = PA_W'({entry[31:8], 12'h000}) + PA_W'(offset);

  always_comb begin
    upd_entry = entry;
    upd_entry[REF_BIT] = 1'b1;
    if (is_write) upd_entry[MOD_BIT] = 1'b1;
  end

  assign need_wb = !entry[REF_BIT] || (is_write && !entry[MOD_BIT]);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic             cfg_boot,
  input  logic [31:0]      ctx_ptr,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic [PA_W-1:0]  prom_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_va,
  input  logic [1:0]       req_acc,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [11:0]      fault_code,
  output logic [PA_W-1:0]  res_pa,
  output logic [1:0]       res_size,
  output logic [31:0]      res_pte,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [31:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_rdata,
  input  logic             mem_rsp_err
);
  localparam int BOOT_W = 19;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_WB_REQ,
    S_WB_WAIT
  } state_e;

  state_e           state_q;
  logic [1:0]       lvl_q;
  logic [19:0]      va_hi_q;
  logic             wr_q;

  logic [PA_W-1:0]  root_addr, next_addr, leaf_pa, pass_pa;
  step_e            step;
  logic [FC_W-1:0]  step_code;
  page_size_e       leaf_size;
  logic [31:0]      upd_entry;
  logic             need_wb;

  ptw_addr_calc #(.PA_W(PA_W), .CTX_W(CTX_W)) u_addr (
    .ctx_ptr   (ctx_ptr),
    .ctx_num   (ctx_num),
    .desc_base (mem_rsp_rdata[31:2]),
    .lvl       (lvl_q),
    .va_hi     (va_hi_q),
    .root_addr (root_addr),
    .next_addr (next_addr)
  );

  ptw_classify u_cls (
    .dtype   (mem_rsp_rdata[1:0]),
    .lvl     (lvl_q),
    .bus_err (mem_rsp_err),
    .step    (step),
    .code    (step_code)
  );

  ptw_leaf #(.PA_W(PA_W)) u_leaf (
    .entry     (mem_rsp_rdata),
    .lvl       (lvl_q),
    .va_mid    (va_hi_q[11:0]),
    .is_write  (wr_q),
    .pa        (leaf_pa),
    .size      (leaf_size),
    .upd_entry (upd_entry),
    .need_wb   (need_wb)
  );

  always_comb begin
    if (cfg_boot && req_acc == ACC_FETCH)
      pass_pa = prom_base | PA_W'(req_va[BOOT_W-1:0]);
    else
      pass_pa = PA_W'(req_va);
  end

  assign req_ready = (state_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_IDLE;
      lvl_q         <= '0;
      va_hi_q       <= '0;
      wr_q          <= 1'b0;
      busy          <= 1'b0;
      done          <= 1'b0;
      fault         <= 1'b0;
      fault_code    <= '0;
      res_pa        <= '0;
      res_size      <= PG_4K;
      res_pte       <= '0;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            if (!cfg_enable) begin
              done     <= 1'b1;
              res_pa   <= pass_pa;
              res_size <= PG_4K;
              res_pte  <= '0;
            end else begin
              busy          <= 1'b1;
              lvl_q         <= 2'd0;
              va_hi_q       <= req_va[31:12];
              wr_q          <= (req_acc == ACC_WRITE);
              mem_req_valid <= 1'b1;
              mem_req_we    <= 1'b0;
              mem_req_addr  <= root_addr;
              state_q       <= S_RD_REQ;
            end
          end
        end
        S_RD_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state_q       <= S_RD_WAIT;
          end
        end
        S_RD_WAIT: begin
          if (mem_rsp_valid) begin
            case (step)
              STEP_DESCEND: begin
                lvl_q         <= lvl_q + 2'd1;
                mem_req_addr  <= next_addr;
                mem_req_valid <= 1'b1;
                state_q       <= S_RD_REQ;
              end
              STEP_LEAF: begin
                res_pa   <= leaf_pa;
                res_size <= leaf_size;
                res_pte  <= upd_entry;
                if (need_wb) begin
                  mem_req_valid <= 1'b1;
                  mem_req_we    <= 1'b1;
                  mem_req_wdata <= upd_entry;
                  state_q       <= S_WB_REQ;
                end else begin
                  done    <= 1'b1;
                  busy    <= 1'b0;
                  state_q <= S_IDLE;
                end
              end
              default: begin
                fault      <= 1'b1;
                fault_code <= step_code;
                busy       <= 1'b0;
                state_q    <= S_IDLE;
              end
            endcase
          end
        end
        S_WB_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state_q       <= S_WB_WAIT;
          end
        end
        S_WB_WAIT: begin
          if (mem_rsp_valid) begin
            mem_req_we <= 1'b0;
            done       <= 1'b1;
            busy       <= 1'b0;
            state_q    <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_enable,
  input logic        req_valid,
  input logic        req_ready,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [11:0] fault_code,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_we,
  input logic [5:0]  mem_addr_lo,
  input logic [5:0]  mem_wdata_lo
);

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(done && fault)); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12

  AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |-> (!busy && req_ready)); // R1

  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || fault)); // R1

  AST_MEM_IN_WALK: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr_lo) && $stable(mem_req_we))); // R3

  AST_FAULT_FORMAT: assert property (@(posedge clk) disable iff (rst)
    fault |-> ((fault_code[4:2] == 3'd1 || fault_code[4:2] == 3'd4) && fault_code[1:0] == 2'd0 && fault_code[11:10] == 2'd0)); // R6

  AST_WB_REF_SET: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we) |-> mem_wdata_lo[5]); // R9

  AST_PASS_NO_WALK: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !cfg_enable) |=> (done && !busy && !mem_req_valid)); // R10

endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_enable    (cfg_enable),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .busy          (busy),
  .done          (done),
  .fault         (fault),
  .fault_code    (fault_code),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_addr_lo   (mem_req_addr[5:0]),
  .mem_wdata_lo  (mem_req_wdata[5:0])
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 36;
  localparam int CTX_W = 8;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 1'b0, cfg_boot = 1'b0;
  logic [31:0] ctx_ptr = 32'h0001_0000;
  logic [CTX_W-1:0] ctx_num = 8'd3;
  logic [PA_W-1:0] prom_base = 36'hF_F000_0000;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_va = '0;
  logic [1:0] req_acc = '0;
  logic busy, done, fault;
  logic [11:0] fault_code;
  logic [PA_W-1:0] res_pa;
  logic [1:0] res_size;
  logic [31:0] res_pte;
  logic mem_req_valid, mem_req_we;
  logic mem_req_ready = 1'b1;
  logic [PA_W-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic mem_rsp_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker #(.PA_W(PA_W), .CTX_W(CTX_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_boot(cfg_boot),
    .ctx_ptr(ctx_ptr), .ctx_num(ctx_num), .prom_base(prom_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_acc(req_acc),
    .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
    .res_pa(res_pa), .res_size(res_size), .res_pte(res_pte),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_err(mem_rsp_err)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [31:0] mem [logic [PA_W-1:0]];
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [PA_W-1:0] rd_log [0:7];
  logic [PA_W-1:0] wr_addr;
  logic [31:0] wr_data;
  bit stall_en = 1'b0;
  bit err_en = 1'b0;
  logic [PA_W-1:0] err_addr = '0;

  logic got_done, got_fault, after_pulse, saw_ready_busy, held_ok;
  logic [11:0] got_code;
  logic [PA_W-1:0] got_pa;
  logic [1:0] got_size;
  logic [31:0] got_pte;

  // memory model: decisions made at the falling edge, seen at the next rising edge
  initial begin
    bit pend;
    bit pend_we;
    logic [PA_W-1:0] pend_addr;
    logic [31:0] pend_wdata;
    pend = 1'b0;
    pend_we = 1'b0;
    pend_addr = '0;
    pend_wdata = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        if (pend_we) begin
          mem[pend_addr] = pend_wdata;
          wr_cnt = wr_cnt + 1;
          wr_addr = pend_addr;
          wr_data = pend_wdata;
          mem_rsp_rdata = '0;
        end else begin
          mem_rsp_rdata = mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
          mem_rsp_err = err_en && (pend_addr == err_addr);
          if (rd_cnt < 8) rd_log[rd_cnt] = pend_addr;
          rd_cnt = rd_cnt + 1;
        end
        pend = 1'b0;
      end
      mem_req_ready = stall_en ? ~mem_req_ready : 1'b1;
      if (!rst && mem_req_valid && mem_req_ready) begin
        pend = 1'b1;
        pend_we = mem_req_we;
        pend_addr = mem_req_addr;
        pend_wdata = mem_req_wdata;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] va, input logic [1:0] acc);
    int guard;
    logic [PA_W-1:0] pa_snap;
    rd_cnt = 0;
    wr_cnt = 0;
    saw_ready_busy = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_va = va;
    req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!(done || fault) && guard < 300) begin
      if (busy && req_ready) saw_ready_busy = 1'b1;
      @(negedge clk);
      guard++;
    end
    got_done = done;
    got_fault = fault;
    got_code = fault_code;
    got_pa = res_pa;
    got_size = res_size;
    got_pte = res_pte;
    pa_snap = res_pa;
    @(negedge clk);
    after_pulse = done || fault;
    held_ok = (res_pa == pa_snap);
  endtask

  task automatic t_reset;
    check(!busy && req_ready && !done && !fault && !mem_req_valid, "R1 reset state",
          {busy, req_ready, done, fault, mem_req_valid}, 5'b01000);
  endtask

  task automatic t_passthrough;
    cfg_enable = 1'b0; cfg_boot = 1'b0;
    run_req(32'h1234_5678, 2'd0);
    check(got_done && got_pa == 36'h0_1234_5678 && got_size == 2'd0, "R10 pass-through result", got_pa, 36'h0_1234_5678);
    check(rd_cnt == 0 && wr_cnt == 0, "R10 no memory access", rd_cnt + wr_cnt, 0);
    check(!after_pulse && held_ok, "R12 pulse width and hold", after_pulse, 0);
  endtask

  task automatic t_boot;
    cfg_enable = 1'b0; cfg_boot = 1'b1;
    run_req(32'hABCD_E123, 2'd2);
    check(got_done && got_pa == 36'hF_F005_E123, "R11 boot fetch to ROM", got_pa, 36'hF_F005_E123);
    run_req(32'hABCD_E123, 2'd0);
    check(got_pa == 36'h0_ABCD_E123, "R11 boot read passes through", got_pa, 36'h0_ABCD_E123);
    cfg_boot = 1'b0;
  endtask

  task automatic t_walk_4k;
    cfg_enable = 1'b1; ctx_num = 8'd3;
    run_req(32'h0848_3000, 2'd0);
    check(rd_log[0] == 36'h10000C, "R2 root read address", rd_log[0], 36'h10000C);
    check(rd_log[1] == 36'h200020 && rd_log[2] == 36'h201048 && rd_log[3] == 36'h20200C && rd_cnt == 4,
          "R3 descriptor chain", rd_log[3], 36'h20200C);
    check(got_done && got_pa == 36'h3_4567_8000 && got_size == 2'd0, "R5 4KB leaf", got_pa, 36'h3_4567_8000);
    check(wr_cnt == 1 && wr_addr == 36'h20200C && wr_data == 32'h3456_783E, "R9 referenced write-back", wr_data, 32'h3456_783E);
    check(got_pte == 32'h3456_783E, "R9 returned entry", got_pte, 32'h3456_783E);
    check(!saw_ready_busy, "R1 not ready while busy", saw_ready_busy, 0);
    check(!after_pulse && held_ok, "R12 done pulse and hold", after_pulse, 0);
    run_req(32'h0848_3000, 2'd0);
    check(got_done && wr_cnt == 0, "R9 no write when referenced", wr_cnt, 0);
    run_req(32'h0848_3000, 2'd1);
    check(wr_cnt == 1 && wr_data == 32'h3456_787E, "R9 modified write-back", wr_data, 32'h3456_787E);
    run_req(32'h0848_3000, 2'd1);
    check(got_done && wr_cnt == 0, "R9 no write when modified", wr_cnt, 0);
  endtask

  task automatic t_walk_256k;
    run_req(32'h0C8C_5000, 2'd0);
    check(got_done && got_pa == 36'h1_2340_5000 && got_size == 2'd1, "R5 256KB leaf", got_pa, 36'h1_2340_5000);
    check(rd_cnt == 3 && wr_cnt == 0, "R5 256KB read count", rd_cnt, 3);
  endtask

  task automatic t_walk_16m;
    run_req(32'h10AB_C000, 2'd2);
    check(got_done && got_pa == 36'h5_00AB_C000 && got_size == 2'd2, "R4 16MB leaf", got_pa, 36'h5_00AB_C000);
    check(rd_cnt == 2, "R4 16MB read count", rd_cnt, 2);
  endtask

  task automatic t_stall;
    stall_en = 1'b1;
    run_req(32'h0C8C_5000, 2'd0);
    check(got_done && got_pa == 36'h1_2340_5000, "R3 walk under throttled memory", got_pa, 36'h1_2340_5000);
    stall_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_fault(input logic [31:0] va, input logic [11:0] code, input string req);
    run_req(va, 2'd0);
    check(got_fault && !got_done && got_code == code, req, got_code, code);
  endtask

  task automatic t_faults;
    ctx_num = 8'd5;
    expect_fault(32'h0848_3000, 12'h004, "R6 invalid root");
    ctx_num = 8'd6;
    expect_fault(32'h0848_3000, 12'h010, "R7 leaf at root");
    ctx_num = 8'd3;
    expect_fault(32'h2000_0000, 12'h104, "R6 invalid level 1");
    expect_fault(32'h2100_0000, 12'h110, "R7 reserved level 1");
    expect_fault(32'h0804_0000, 12'h204, "R6 invalid level 2");
    expect_fault(32'h0848_4000, 12'h310, "R7 pointer at level 3");
    expect_fault(32'h0848_5000, 12'h304, "R6 invalid level 3");
    check(!after_pulse, "R12 fault pulse width", after_pulse, 0);
  endtask

  task automatic t_bus_err;
    err_en = 1'b1; err_addr = 36'h201048;
    run_req(32'h0848_3000, 2'd1);
    check(got_fault && got_code == 12'h210, "R8 bus error fault", got_code, 12'h210);
    check(wr_cnt == 0, "R8 no write after bus error", wr_cnt, 0);
    err_en = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    mem[36'h10000C] = 32'h0002_0001;
    mem[36'h100018] = 32'h0000_0002;
    mem[36'h200020] = 32'h0002_0101;
    mem[36'h200030] = 32'h0002_0301;
    mem[36'h200040] = 32'h5000_007E;
    mem[36'h200084] = 32'h0000_0003;
    mem[36'h201048] = 32'h0002_0201;
    mem[36'h20200C] = 32'h3456_781E;
    mem[36'h202010] = 32'h0002_0201;
    mem[36'h20308C] = 32'h1234_007E;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_passthrough();
    t_boot();
    t_walk_4k();
    t_walk_256k();
    t_walk_16m();
    t_stall();
    t_faults();
    t_bus_err();
    finish_run();
  end

endmodule